// File: doc/BRIEF.md
# Clock Enable Tree: Source Select, Cascaded Divide and Gating

This block turns one fast reference clock into a family of clock-enable pulses: a processor enable, a double-rate memory enable pair, a set of bus enables, a set of peripheral enables and two special enables. Every output is a one-reference-cycle pulse that downstream logic uses as a clock enable. No divided clock net is built. Three clock groups each pick either a shared bypass tick or their own PLL tick. A path-select bit decides whether group 0 or group 1 feeds the bus divider chain.

The bus chain is a cascade of dividers. The double-rate memory divider works from the selected source. The bus divider works from the memory enable. The peripheral divider works from the bus enable. The peripheral factor must be even, or exactly one. A write that would give an odd factor above one is rounded up to the next even factor, and a sticky flag records that the rounding happened. A divider takes a new ratio only at its own terminal count. Each output has a mask bit; masking holds that output low while its divider keeps counting.

Software writes the configuration through a write-only port with an enable, a 2-bit address and an 11-bit data word. Each output is registered, so it appears one reference cycle after its source tick.

Top module: `clken_tree`

## Requirements
- R1: After reset, all groups select the bypass tick, the path select is 0, every divide field is 0 (divide by 1), every mask bit is 1 and `fix_flag` is 0.
- R2: Address 0 bits [2:0] set the sources of groups 0..2 (0 = `byp_tick`, 1 = `pll_tick[g]`). Group 0 feeds `cpu_ce`. Group 2 feeds the special enables. Each bit acts on its own group only.
- R3: Address 0 bit 3 selects the source of the bus chain: 0 = group 0, 1 = group 1.
- R4: Address 1 bits [2:0] hold k for the processor divider. `cpu_ce` pulses once per k+1 group-0 ticks.
- R5: Address 1 holds three more divide fields. Bits [5:3] hold k for the memory enable, which divides the bus-chain source by k+1. Bit 6 holds k for the bus enable, which divides the memory enable by k+1. Bits [10:7] hold k for the peripheral enable, which divides the bus enable by the stored factor.
- R6: A peripheral field written with an even nonzero k (an odd factor above 1) is stored as k+1. Other values are stored as written.
- R7: `fix_flag` is set by any write that R6 rounds. Only reset clears it.
- R8: A new divide value takes effect at the divider's next terminal count. Every pulse interval equals either the old period or the new period.
- R9: Address 2 holds the masks for `mem_ce` (bits [1:0]) and `bus_ce` (bits [NBUS+1:2]). Address 3 holds the masks for `per_ce` (bits [NPER-1:0]) and `spc_ce` (bits [NPER+1:NPER]). A 0 holds that output low and leaves the other outputs unaffected.
- R10: A masked output runs in phase with its unmasked siblings again once it is unmasked.
- R11: `spc_ce` follows the group-2 source undivided, subject to its masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 11 | Register write data |
| byp_tick | input | 1 | Bypass source tick |
| pll_tick | input | 3 | Per-group PLL source ticks |
| cpu_ce | output | 1 | Processor enable |
| mem_ce | output | 2 | Double-rate memory enables |
| bus_ce | output | NBUS | Bus enables |
| per_ce | output | NPER | Peripheral enables |
| spc_ce | output | 2 | Special enables |
| fix_flag | output | 1 | Sticky peripheral rounding flag |

## Verification
The hardest case to reach is a ratio change that lands in the middle of a divider count. Pulse counts cannot show whether that period was truncated or stretched. The stimulus first runs the processor divider at divide-by-8. It then rewrites the ratio to divide-by-2 a few cycles after a pulse. While this happens, it measures the spacing of every pair of consecutive `cpu_ce` pulses. Every other check counts pulses over a window whose length is a multiple of every period, so each expected count can be derived from the ratios alone, whatever the phase.

// File: rtl/clken_pkg.sv
// Shared constants and types for the clock enable tree.
// Register addresses and field positions live here so that the register file
// and any user of the map agree on them.
package clken_pkg;
    localparam int DATA_W  = 11;
    localparam int NGRP    = 3;
    localparam int CPU_KW  = 3;
    localparam int DBL_KW  = 3;
    localparam int BUS_KW  = 1;
    localparam int PER_KW  = 4;

    localparam logic [1:0] A_SRC   = 2'd0;
    localparam logic [1:0] A_DIV   = 2'd1;
    localparam logic [1:0] A_BGATE = 2'd2;
    localparam logic [1:0] A_PGATE = 2'd3;

    // Field positions inside the divide register
    localparam int CPU_LSB = 0;
    localparam int DBL_LSB = CPU_LSB + CPU_KW;
    localparam int BUS_LSB = DBL_LSB + DBL_KW;
    localparam int PER_LSB = BUS_LSB + BUS_KW;

    typedef struct packed {
        logic [PER_KW-1:0] per_k;
        logic [BUS_KW-1:0] bus_k;
        logic [DBL_KW-1:0] dbl_k;
        logic [CPU_KW-1:0] cpu_k;
    } div_cfg_t;
endpackage

// File: rtl/cg_regs.sv
// Configuration registers of the clock enable tree.
// Holds source selects, the bus path select, the divide fields and all mask
// bits. Peripheral divide values with an odd factor above one are rounded up
// to the next even factor on write, and a sticky flag records the rounding.
// Assumes NBUS+2 and NPER+2 do not exceed DATA_W.
module cg_regs
    import clken_pkg::*;
#(
    parameter int NBUS = 4,
    parameter int NPER = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [NGRP-1:0]         src_sel,
    output logic                    bus_pick,
    output div_cfg_t                div_cfg,
    output logic [1:0]              mem_gate,
    output logic [NBUS-1:0]         bus_gate,
    output logic [NPER-1:0]         per_gate,
    output logic [1:0]              spc_gate,
    output logic                    fix_flag
);
    logic [PER_KW-1:0] per_raw;
    logic              per_odd;
    logic [PER_KW-1:0] per_fixed;

    // Detect a peripheral value with an odd factor above one and round it up
    always_comb begin
        per_raw   = wr_data[PER_LSB +: PER_KW];
        per_odd   = (per_raw != '0) && !per_raw[0];
        per_fixed = per_odd ? per_raw + 1'b1 : per_raw;
    end

    // Register writes, one address per register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel  <= '0;
            bus_pick <= 1'b0;
            div_cfg  <= '0;
            mem_gate <= '1;
            bus_gate <= '1;
            per_gate <= '1;
            spc_gate <= '1;
            fix_flag <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_SRC: begin
                    src_sel  <= wr_data[NGRP-1:0];
                    bus_pick <= wr_data[NGRP];
                end
                A_DIV: begin
                    div_cfg.cpu_k <= wr_data[CPU_LSB +: CPU_KW];
                    div_cfg.dbl_k <= wr_data[DBL_LSB +: DBL_KW];
                    div_cfg.bus_k <= wr_data[BUS_LSB +: BUS_KW];
                    div_cfg.per_k <= per_fixed;
                    if (per_odd) fix_flag <= 1'b1;
                end
                A_BGATE: begin
                    mem_gate <= wr_data[1:0];
                    bus_gate <= wr_data[2 +: NBUS];
                end
                default: begin
                    per_gate <= wr_data[NPER-1:0];
                    spc_gate <= wr_data[NPER +: 2];
                end
            endcase
        end
    end

    // Rounded write lands as k+1 and raises the flag
    assert_round_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DIV && wr_data[PER_LSB +: PER_KW] != '0 && !wr_data[PER_LSB])
        |=> (div_cfg.per_k == $past(wr_data[PER_LSB +: PER_KW]) + 1'b1) && fix_flag);

    // Flag never drops outside reset
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fix_flag |=> fix_flag);
endmodule

// File: rtl/cg_div.sv
// Enable-pulse divider.
// Counts input enables and passes one through every k+1 of them. The
// requested ratio is loaded only at the terminal count, so no period is cut
// short or stretched. The output is combinational from in_ce so cascaded
// dividers stay aligned to the same reference cycle.
module cg_div #(
    parameter int KW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_ce,
    input  logic [KW-1:0] k_req,
    output logic          out_ce
);
    logic [KW-1:0] cnt;
    logic [KW-1:0] act;
    logic          term;

    // Terminal count of the active ratio
    assign term   = (cnt == act);
    assign out_ce = in_ce && term;

    // Count source enables; reload the ratio at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            act <= '0;
        end else if (in_ce) begin
            if (term) begin
                cnt <= '0;
                act <= k_req;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_cnt_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act);

    assert_ratio_at_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ce && term) |=> $stable(act));

    assert_out_needs_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_ce |-> in_ce);
endmodule

// File: rtl/cg_gate.sv
// Mask-and-register stage for a group of outputs sharing one base enable.
// Each lane is held low when its mask bit is 0. The divider behind it keeps
// counting regardless, so unmasking returns the lane in phase.
module cg_gate #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         base_ce,
    input  logic [W-1:0] gate,
    output logic [W-1:0] out_ce
);
    // Register the masked copies of the base enable
    always_ff @(posedge clk) begin
        if (!rst_n) out_ce <= '0;
        else        out_ce <= {W{base_ce}} & gate;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        assert_mask_holds_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !gate[i] |=> !out_ce[i]);
        assert_lane_in_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (gate[i] && base_ce) |=> out_ce[i]);
    end
endmodule

// File: rtl/clken_tree.sv
// Clock enable tree: source select, cascaded dividers and output masks.
// Group 0 drives the processor divider. Group 0 or group 1 (path select)
// drives the memory -> bus -> peripheral chain. Group 2 drives the special
// enables directly. All outputs are registered pulses, one reference cycle
// after their source tick.
module clken_tree
    import clken_pkg::*;
#(
    parameter int NBUS = 4,
    parameter int NPER = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              byp_tick,
    input  logic [NGRP-1:0]   pll_tick,
    output logic              cpu_ce,
    output logic [1:0]        mem_ce,
    output logic [NBUS-1:0]   bus_ce,
    output logic [NPER-1:0]   per_ce,
    output logic [1:0]        spc_ce,
    output logic              fix_flag
);
    logic [NGRP-1:0] src_sel;
    logic            bus_pick;
    div_cfg_t        div_cfg;
    logic [1:0]      mem_gate;
    logic [NBUS-1:0] bus_gate;
    logic [NPER-1:0] per_gate;
    logic [1:0]      spc_gate;

    logic [NGRP-1:0] grp_tick;
    logic            chain_src;
    logic            cpu_base, dbl_base, bus_base, per_base;

    cg_regs #(.NBUS(NBUS), .NPER(NPER)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .src_sel(src_sel), .bus_pick(bus_pick),
        .div_cfg(div_cfg), .mem_gate(mem_gate), .bus_gate(bus_gate),
        .per_gate(per_gate), .spc_gate(spc_gate), .fix_flag(fix_flag)
    );

    // Per-group choice between bypass tick and own PLL tick
    for (genvar g = 0; g < NGRP; g++) begin : g_src
        assign grp_tick[g] = src_sel[g] ? pll_tick[g] : byp_tick;
    end

    // Bus chain source picks group 0 or group 1
    assign chain_src = bus_pick ? grp_tick[1] : grp_tick[0];

    cg_div #(.KW(CPU_KW)) u_cpu_div (
        .clk(clk), .rst_n(rst_n), .in_ce(grp_tick[0]),
        .k_req(div_cfg.cpu_k), .out_ce(cpu_base)
    );
    cg_div #(.KW(DBL_KW)) u_dbl_div (
        .clk(clk), .rst_n(rst_n), .in_ce(chain_src),
        .k_req(div_cfg.dbl_k), .out_ce(dbl_base)
    );
    cg_div #(.KW(BUS_KW)) u_bus_div (
        .clk(clk), .rst_n(rst_n), .in_ce(dbl_base),
        .k_req(div_cfg.bus_k), .out_ce(bus_base)
    );
    cg_div #(.KW(PER_KW)) u_per_div (
        .clk(clk), .rst_n(rst_n), .in_ce(bus_base),
        .k_req(div_cfg.per_k), .out_ce(per_base)
    );

    cg_gate #(.W(1)) u_cpu_out (
        .clk(clk), .rst_n(rst_n), .base_ce(cpu_base), .gate(1'b1), .out_ce(cpu_ce)
    );
    cg_gate #(.W(2)) u_mem_out (
        .clk(clk), .rst_n(rst_n), .base_ce(dbl_base), .gate(mem_gate), .out_ce(mem_ce)
    );
    cg_gate #(.W(NBUS)) u_bus_out (
        .clk(clk), .rst_n(rst_n), .base_ce(bus_base), .gate(bus_gate), .out_ce(bus_ce)
    );
    cg_gate #(.W(NPER)) u_per_out (
        .clk(clk), .rst_n(rst_n), .base_ce(per_base), .gate(per_gate), .out_ce(per_ce)
    );
    cg_gate #(.W(2)) u_spc_out (
        .clk(clk), .rst_n(rst_n), .base_ce(grp_tick[2]), .gate(spc_gate), .out_ce(spc_ce)
    );

    // Cascade nesting: each stage only fires with its parent
    assert_bus_within_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_base |-> dbl_base);
    assert_per_within_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        per_base |-> bus_base);
    assert_chain_from_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_base |-> (bus_pick ? grp_tick[1] : grp_tick[0]));
endmodule

// File: tb/clken_tree_test.sv
// Scoreboard bench: the driver pushes expected pulse counts per window,
// the monitor counts output pulses and compares when a window closes.
module clken_tree_test;
    localparam int CLK_PERIOD = 10;
    localparam int NBUS = 4;
    localparam int NPER = 4;
    localparam int WIN  = 1536;
    localparam int NCH  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [10:0] wr_data = '0;
    logic byp_tick = 1'b0;
    logic [2:0] pll_tick = '0;
    logic cpu_ce, fix_flag;
    logic [1:0] mem_ce, spc_ce;
    logic [NBUS-1:0] bus_ce;
    logic [NPER-1:0] per_ce;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit win_on = 1'b0;
    bit done = 1'b0;
    int cnt [NCH];

    typedef struct { string tag; int exp [NCH]; } item_t;
    item_t sbq [$];
    event win_done;

    bit gap_on = 1'b0;
    int last_pos = -1;
    int bad_gap = 0, seen2 = 0, seen8 = 0;

    clken_tree #(.NBUS(NBUS), .NPER(NPER)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .byp_tick(byp_tick), .pll_tick(pll_tick),
        .cpu_ce(cpu_ce), .mem_ce(mem_ce), .bus_ce(bus_ce), .per_ce(per_ce),
        .spc_ce(spc_ce), .fix_flag(fix_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Source ticks: bypass every 4, pll0 every cycle, pll1 every 2, pll2 every 3
    initial forever begin
        @(negedge clk);
        cyc++;
        byp_tick    = (cyc % 4 == 0);
        pll_tick[0] = 1'b1;
        pll_tick[1] = (cyc % 2 == 0);
        pll_tick[2] = (cyc % 3 == 0);
    end

    // Monitor: count pulses in the window and track processor pulse spacing
    initial forever begin
        @(negedge clk);
        if (win_on) begin
            cnt[0] += int'(cpu_ce);
            cnt[1] += int'(mem_ce[0]);
            cnt[2] += int'(mem_ce[1]);
            cnt[3] += int'(bus_ce[0]);
            cnt[4] += int'(bus_ce[2]);
            cnt[5] += int'(per_ce[0]);
            cnt[6] += int'(per_ce[1]);
            cnt[7] += int'(spc_ce[0]);
            cnt[8] += int'(spc_ce[1]);
            cnt[9] += int'((bus_ce[0] != bus_ce[2]) || (per_ce[0] != per_ce[1]));
        end
        if (gap_on && cpu_ce) begin
            if (last_pos >= 0) begin
                if (cyc - last_pos == 2) seen2++;
                else if (cyc - last_pos == 8) seen8++;
                else bad_gap++;
            end
            last_pos = cyc;
        end
    end

    // Monitor: compare counts against the popped expectation
    initial forever begin
        item_t it;
        @(win_done);
        it = sbq.pop_front();
        for (int c = 0; c < NCH; c++) begin
            if (it.exp[c] >= 0) begin
                checks++;
                if (cnt[c] != it.exp[c]) begin
                    errors++;
                    $display("FAIL %s channel %0d: actual=%0d expected=%0d",
                             it.tag, c, cnt[c], it.exp[c]);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 11'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int divw(int cpu, int dbl, int bus, int per);
        return cpu | (dbl << 3) | (bus << 6) | (per << 7);
    endfunction

    // Driver: settle, count over a window, push the expectation
    task automatic window(input string tag, input int e0, e1, e2, e3, e4,
                          e5, e6, e7, e8, e9);
        item_t it;
        repeat (256) @(negedge clk);
        for (int c = 0; c < NCH; c++) cnt[c] = 0;
        win_on = 1'b1;
        repeat (WIN) @(negedge clk);
        win_on = 1'b0;
        it.tag = tag;
        it.exp = '{e0, e1, e2, e3, e4, e5, e6, e7, e8, e9};
        sbq.push_back(it);
        ->win_done;
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 outputs low in reset", int'({cpu_ce, mem_ce, bus_ce, per_ce, spc_ce}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flag clear", int'(fix_flag), 0);
        // R1: everything on bypass (period 4), divide by 1, unmasked
        window("R1 reset config", 384, 384, 384, 384, 384, 384, 384, 384, 384, 0);
        // R2 R11: all groups on PLL
        wr(2'd0, 'h7);
        window("R2 R11 all pll", 1536, 1536, -1, 1536, -1, 1536, -1, 512, 512, -1);
        // R2: only group 1 on PLL, chain from group 0
        wr(2'd0, 'h2);
        window("R2 group independence", 384, 384, -1, 384, -1, 384, -1, 384, -1, -1);
        // R3: chain switched to group 1
        wr(2'd0, 'hA);
        window("R3 path select", 384, 768, -1, 768, -1, 768, -1, 384, -1, -1);
        // R4 R5: cascade ratios
        wr(2'd0, 'h7);
        wr(2'd1, divw(3, 1, 1, 3));
        window("R4 R5 cascade", 384, 768, 768, 384, 384, 96, 96, 512, -1, -1);
        wr(2'd0, 'hF);
        window("R3 R5 chain on group1", 384, 384, -1, 192, -1, 48, -1, -1, -1, -1);
        // R6 R7: odd factor 3 rounded to 4
        wr(2'd1, divw(3, 1, 1, 2));
        window("R6 rounded peripheral", -1, -1, -1, 192, -1, 48, -1, -1, -1, -1);
        check("R7 flag set", int'(fix_flag), 1);
        // R6 factor 1 kept, R7 flag stays
        wr(2'd1, divw(3, 1, 1, 0));
        window("R6 factor one kept", -1, -1, -1, 192, -1, 192, 192, -1, -1, -1);
        check("R7 flag sticky", int'(fix_flag), 1);
        // R9: masks
        wr(2'd2, 'h2D);
        wr(2'd3, 'h1D);
        window("R9 masks", 384, 384, 0, 192, 0, 192, 0, 512, 0, -1);
        // R10: unmask, lanes in phase
        wr(2'd2, 'h3F);
        wr(2'd3, 'h3F);
        window("R10 unmask phase", -1, -1, 384, 192, 192, 192, 192, -1, 512, 0);
        // R8: change processor ratio 8 -> 2 mid-count
        wr(2'd1, divw(7, 1, 1, 0));
        repeat (256) @(negedge clk);
        last_pos = -1; gap_on = 1'b1;
        repeat (40) @(negedge clk);
        @(negedge clk iff cpu_ce);
        repeat (2) @(negedge clk);
        wr(2'd1, divw(1, 1, 1, 0));
        repeat (60) @(negedge clk);
        gap_on = 1'b0;
        check("R8 no odd interval", bad_gap, 0);
        check("R8 old period seen", int'(seen8 > 0), 1);
        check("R8 new period seen", int'(seen2 > 0), 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule